// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Process Tags

This block caches recent virtual-to-physical page mappings so that a 32-bit virtual address can be translated in the same cycle it is presented. Each of its entries holds a valid flag, a write-enable (dirty) flag, a 20-bit virtual page tag, a 6-bit process identifier and a 20-bit physical page number. On every lookup all entries are compared at once. The result is one of three outcomes: a hit with a physical address, a miss, or a write-protect fault.

A miss handler outside the block walks the page tables and installs the mapping through the refill port. Refill places the mapping in a free entry when one exists. When every entry is in use, a round-robin pointer picks the entry to evict. If the page and process already have an entry, refill rewrites that entry in place, so no two entries can ever match the same lookup. A flush input drops every mapping, for example on a global address-space change.

Top module: `fa_tlb`

## Requirements
- R1: After synchronous reset every entry is invalid, so any valid lookup reports a miss (hit=0, miss=1, fault=0, physical address 0).
- R2: A valid lookup whose virtual page number (address bits 31..12) and process ID both equal those of a valid entry reports a hit. The physical address is that entry's 20-bit physical page in bits 31..12, with bits 11..0 copied unchanged from the virtual address.
- R3: An entry whose page tag matches but whose process ID differs from the lookup's does not match, and the lookup misses.
- R4: When no valid entry matches, the lookup reports miss=1, hit=0, fault=0 and a physical address of 0. Hit, miss and fault are mutually exclusive.
- R5: A write lookup that matches an entry with dirty=0 reports fault=1, hit=0, miss=0 and a physical address of 0. A read of the same entry hits. A write to an entry with dirty=1 hits.
- R6: Lookup is combinational. A refill takes effect at the next rising clock edge, so a lookup in the same cycle as the refill still sees the old contents.
- R7: While any entry is invalid, a refill of a new page/process pair fills an invalid entry and evicts no valid mapping. Sixteen distinct refills after a flush all remain resident.
- R8: When every entry is valid, a refill of a new pair evicts the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one after each eviction. Entries fill in ascending index order, so after a full fill the first eviction removes the first-installed mapping, the second removes the second, and so on.
- R9: A refill whose page tag and process ID equal those of a valid entry overwrites that entry's physical page and dirty flag. It evicts no other entry and does not advance the round-robin pointer.
- R10: An asserted flush invalidates every entry at the next rising edge. A refill in the same cycle is discarded.
- R11: With the lookup-valid input low, hit, miss and fault are 0 and the physical address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Process ID of the requesting context |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Translation valid |
| lk_miss | output | 1 | No matching entry (miss exception) |
| lk_wprot | output | 1 | Write to a write-protected page (write-protect exception) |
| lk_paddr | output | 32 | Translated physical address, 0 unless hit |
| rf_valid | input | 1 | Install a mapping at the next edge |
| rf_vpn | input | 20 | Virtual page tag to install |
| rf_asid | input | 6 | Process ID to install |
| rf_ppn | input | 20 | Physical page number to install |
| rf_dirty | input | 1 | Write-enable flag to install |
| flush | input | 1 | Invalidate all entries at the next edge |

## Verification
The assertions take for granted that the contents only change through refill, flush and reset, so at most one entry can ever match a lookup. The one-match check and the output-exclusivity check both build on this. They also assume that the lookup and refill inputs are driven to known values whenever reset is low. The bench meets this by driving every input from time zero, and it changes inputs only after falling edges. Refills are held for exactly one rising edge, so each refill and each flush is seen only once. Distinct refills use distinct page/process pairs, except in the scenario that tests the duplicate case on purpose.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 20;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int ASID_W = 6;

    typedef struct packed {
        logic              vld;
        logic              dirty;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;

    function automatic logic entry_matches(tlb_entry_t e, logic [VPN_W-1:0] v,
                                           logic [ASID_W-1:0] a);
        return e.vld && (e.vpn == v) && (e.asid == a);
    endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N     = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  tlb_entry_t        ents [N],
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic [N-1:0]      hits,
    output logic              any,
    output logic [IDX_W-1:0]  idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = entry_matches(ents[g], vpn, asid);
    end

    assign any = |hits;

    // Vector is one-hot or zero, so OR-ing the indices encodes it.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hits[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     valids,
    input  logic             advance,
    output logic             full,
    output logic [IDX_W-1:0] pick
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;

    assign full = &valids;

    // Lowest-index invalid entry wins.
    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valids[i]) free_idx = IDX_W'(i);
        end
    end

    assign pick = full ? rr_ptr : free_idx;

    always_ff @(posedge clk) begin
        if (rst)          rr_ptr <= '0;
        else if (advance) rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(rr_ptr));

    // R8
    evict_only_full_chk: assert property (@(posedge clk) disable iff (rst)
        advance |-> full);
endmodule

// File: rtl/fa_tlb.sv
module fa_tlb
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_wprot,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic              rf_dirty,
    input  logic              flush
);
    localparam int IDX_W = $clog2(NUM_ENTRIES);

    tlb_entry_t             ents [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] valids;
    logic [NUM_ENTRIES-1:0] lk_hits, rf_hits;
    logic                   lk_any, rf_dup, full, advance;
    logic [IDX_W-1:0]       lk_idx, rf_idx, vic_idx, wr_idx;
    tlb_entry_t             sel, new_ent;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_vld
        assign valids[g] = ents[g].vld;
    end

    tlb_match #(.N(NUM_ENTRIES)) u_lk_match (
        .ents(ents), .vpn(lk_vaddr[VA_W-1:OFF_W]), .asid(lk_asid),
        .hits(lk_hits), .any(lk_any), .idx(lk_idx)
    );

    tlb_match #(.N(NUM_ENTRIES)) u_rf_match (
        .ents(ents), .vpn(rf_vpn), .asid(rf_asid),
        .hits(rf_hits), .any(rf_dup), .idx(rf_idx)
    );

    assign advance = rf_valid && !flush && !rf_dup && full;

    tlb_victim #(.N(NUM_ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .valids(valids), .advance(advance),
        .full(full), .pick(vic_idx)
    );

    assign wr_idx  = rf_dup ? rf_idx : vic_idx;
    assign new_ent = '{vld: 1'b1, dirty: rf_dirty, vpn: rf_vpn, asid: rf_asid, ppn: rf_ppn};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ents[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < NUM_ENTRIES; i++) ents[i].vld <= 1'b0;
        end else if (rf_valid) begin
            ents[wr_idx] <= new_ent;
        end
    end

    // Lookup result
    assign sel = ents[lk_idx];

    always_comb begin
        lk_hit   = 1'b0;
        lk_miss  = 1'b0;
        lk_wprot = 1'b0;
        lk_paddr = '0;
        if (lk_valid) begin
            if (!lk_any)                      lk_miss  = 1'b1;
            else if (lk_write && !sel.dirty)  lk_wprot = 1'b1;
            else begin
                lk_hit   = 1'b1;
                lk_paddr = {sel.ppn, lk_vaddr[OFF_W-1:0]};
            end
        end
    end

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hits) && $onehot0(rf_hits));

    // R4
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lk_hit, lk_miss, lk_wprot}));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    // R5
    wprot_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        lk_wprot |-> (lk_write && lk_paddr == '0));

    // R7
    fill_grows_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_valid && !flush && !rf_dup && !full) |=>
            $countones(valids) == $past($countones(valids)) + 1);

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valids == '0));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_wprot));
endmodule

// File: tb/fa_tlb_test.sv
module fa_tlb_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_miss, lk_wprot;
    logic [31:0] lk_paddr;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [5:0]  rf_asid = '0;
    logic [19:0] rf_ppn = '0;
    logic        rf_dirty = 1'b0;
    logic        flush = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;   // 50 MHz

    fa_tlb uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_write(lk_write), .lk_hit(lk_hit),
        .lk_miss(lk_miss), .lk_wprot(lk_wprot), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid),
        .rf_ppn(rf_ppn), .rf_dirty(rf_dirty), .flush(flush)
    );

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Flags {hit,miss,wprot} and paddr, sampled 2 ns after driving.
    task automatic look(input string req, input logic [19:0] vpn, input logic [5:0] asid,
                        input logic wr, input logic [11:0] off,
                        input logic [2:0] exp_f, input logic [31:0] exp_pa);
        lk_valid = 1'b1;
        lk_vaddr = {vpn, off};
        lk_asid  = asid;
        lk_write = wr;
        #2;
        check(req, {1'b0, lk_hit, lk_miss, lk_wprot, lk_paddr}, {1'b0, exp_f, exp_pa});
    endtask

    task automatic refill(input logic [19:0] vpn, input logic [5:0] asid,
                          input logic [19:0] ppn, input logic d);
        rf_valid = 1'b1; rf_vpn = vpn; rf_asid = asid; rf_ppn = ppn; rf_dirty = d;
        @(posedge clk); @(negedge clk);
        rf_valid = 1'b0;
    endtask

    localparam logic [2:0] HIT = 3'b100, MISS = 3'b010, WP = 3'b001;

    task automatic t_reset();
        look("R1", 20'h12345, 6'd5, 1'b0, 12'h000, MISS, 32'h0);
        look("R1", 20'h00000, 6'd0, 1'b1, 12'hFFF, MISS, 32'h0);
    endtask

    task automatic t_basic();
        rf_valid = 1'b1; rf_vpn = 20'h12345; rf_asid = 6'd5; rf_ppn = 20'hABCDE; rf_dirty = 1'b1;
        look("R6", 20'h12345, 6'd5, 1'b0, 12'h123, MISS, 32'h0);
        @(posedge clk); @(negedge clk);
        rf_valid = 1'b0;
        look("R6", 20'h12345, 6'd5, 1'b0, 12'h123, HIT, 32'hABCDE123);
        look("R2", 20'h12345, 6'd5, 1'b0, 12'hFA5, HIT, 32'hABCDEFA5);
        look("R5", 20'h12345, 6'd5, 1'b1, 12'h004, HIT, 32'hABCDE004);
    endtask

    task automatic t_asid_miss();
        look("R3", 20'h12345, 6'd6, 1'b0, 12'h010, MISS, 32'h0);
        look("R4", 20'h12346, 6'd5, 1'b0, 12'h010, MISS, 32'h0);
    endtask

    task automatic t_wprot();
        refill(20'h00777, 6'd5, 20'h11111, 1'b0);
        look("R5", 20'h00777, 6'd5, 1'b0, 12'h0AB, HIT, 32'h111110AB);
        look("R5", 20'h00777, 6'd5, 1'b1, 12'h0AB, WP, 32'h0);
    endtask

    task automatic t_idle();
        lk_vaddr = 32'h12345123; lk_asid = 6'd5; lk_write = 1'b0; lk_valid = 1'b0;
        #2;
        check("R11", {3'b0, lk_hit, lk_miss, lk_wprot, lk_paddr}, 36'h0);
    endtask

    task automatic t_flush();
        flush = 1'b1;
        rf_valid = 1'b1; rf_vpn = 20'h0F0F0; rf_asid = 6'd1; rf_ppn = 20'h22222; rf_dirty = 1'b1;
        @(posedge clk); @(negedge clk);
        flush = 1'b0; rf_valid = 1'b0;
        look("R10", 20'h12345, 6'd5, 1'b0, 12'h000, MISS, 32'h0);
        look("R10", 20'h00777, 6'd5, 1'b0, 12'h000, MISS, 32'h0);
        look("R10", 20'h0F0F0, 6'd1, 1'b0, 12'h000, MISS, 32'h0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 16; i++)
            refill(20'h10000 + 20'(i), 6'd3, 20'h0A000 + 20'(i), 1'(i));
        for (int i = 0; i < 16; i++)
            look("R7", 20'h10000 + 20'(i), 6'd3, 1'b0, 12'h055, HIT, {20'h0A000 + 20'(i), 12'h055});
    endtask

    task automatic t_round_robin();
        refill(20'h20000, 6'd3, 20'h0B000, 1'b1);
        look("R8", 20'h10000, 6'd3, 1'b0, 12'h000, MISS, 32'h0);
        look("R8", 20'h10001, 6'd3, 1'b0, 12'h000, HIT, 32'h0A001000);
        look("R8", 20'h20000, 6'd3, 1'b0, 12'h001, HIT, 32'h0B000001);
        refill(20'h20001, 6'd3, 20'h0B001, 1'b1);
        look("R8", 20'h10001, 6'd3, 1'b0, 12'h000, MISS, 32'h0);
        look("R8", 20'h10002, 6'd3, 1'b0, 12'h000, HIT, 32'h0A002000);
    endtask

    task automatic t_duplicate();
        refill(20'h10005, 6'd3, 20'h0CCCC, 1'b0);
        look("R9", 20'h10005, 6'd3, 1'b0, 12'h321, HIT, 32'h0CCCC321);
        look("R9", 20'h10005, 6'd3, 1'b1, 12'h321, WP, 32'h0);
        look("R9", 20'h10002, 6'd3, 1'b0, 12'h000, HIT, 32'h0A002000);
        refill(20'h20002, 6'd3, 20'h0B002, 1'b1);
        look("R9", 20'h10002, 6'd3, 1'b0, 12'h000, MISS, 32'h0);
        look("R8", 20'h10003, 6'd3, 1'b0, 12'h000, HIT, 32'h0A003000);
        look("R9", 20'h10005, 6'd3, 1'b0, 12'h000, HIT, 32'h0CCCC000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_asid_miss();
        t_wprot();
        t_idle();
        t_flush();
        t_fill();
        t_round_robin();
        t_duplicate();
        @(negedge clk);
        finish_run();
    end
endmodule